// File: doc/BRIEF.md
# Circular Descriptor Writer with Pass Stamping

This block is the producer side of a descriptor ring in memory. It takes one eight-word descriptor at a time from a valid/ready stream and writes it into the current slot of a circular buffer, one word per cycle. Each slot is 32 bytes. The slot address is the programmable base plus the head pointer times 32, and within the slot the word offset advances by 4. After the last word of a slot is written, the head pointer advances, wrapping to zero after the last slot, and a one-cycle interrupt pulse is sent to the consumer.

The final word of every descriptor is partly rewritten on the way out. Its top nibble is replaced by a pass counter, and the byte below that by a programmable ring identifier. The pass counter is zero out of reset. It steps each time the producer starts a new pass at slot zero, so every entry of the first pass carries 1, and after 15 the count continues at 0. A consumer that knows which pass it expects can tell a fresh entry from a stale one by bit 28 alone, without reading the head pointer.

The consumer reports its tail slot. The producer refuses a descriptor whenever accepting it would move the head onto the tail. The ring holds 2^n slots, with n set at run time.

Top module: `lap_ring_producer`

## Requirements
- R1: After reset, headPtr is 0, memWrEn and entryIrq are low, and descReady is high while tailPtr is 0.
- R2: An accepted descriptor is written as exactly eight word writes on eight consecutive cycles, starting the cycle after acceptance. Word k (k = 0 first) is bits [32k+31:32k] of descData and goes to address ringBase + headPtr*32 + k*4. Words 0 to 6 are written unchanged.
- R3: Word 7 keeps descData bits [243:224] in its bits [19:0], and its bits [27:20] carry ringId, replacing whatever the stream supplied there.
- R4: Bits [31:28] of word 7 hold the pass count. This count is 0 after reset, and every entry written during the first pass through the ring carries 1.
- R5: The pass count rises by one each time an entry is accepted at slot 0, and it continues at 0 after 15. Every entry of one pass carries the same value.
- R6: The ring has 2^ringSizeLog2 slots, with ringSizeLog2 from 3 to 8; values outside that range are clamped. headPtr counts slots, advances by one per entry, wraps to 0 after the last slot, and changes only in the cycle entryIrq is high.
- R7: descReady is low whenever (headPtr+1) mod size equals tailPtr. A descValid held high while the ring is full causes no write and leaves headPtr unchanged.
- R8: descReady is low during the eight write cycles of an entry. Stream data presented then is not captured.
- R9: entryIrq is high for exactly one cycle, the cycle after word 7 is written. The same clock edge that raises it also advances headPtr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| descValid | input | 1 | Descriptor offered on descData |
| descData | input | 256 | Eight descriptor words, word 0 in the low bits |
| descReady | output | 1 | Producer accepts the offered descriptor this cycle |
| ringId | input | 8 | Identifier stamped into every entry |
| ringBase | input | 32 | Byte address of slot 0, aligned to the ring size |
| ringSizeLog2 | input | 4 | log2 of the number of slots (3 to 8) |
| tailPtr | input | 8 | Consumer's next slot to read |
| memWrEn | output | 1 | Memory word write strobe |
| memWrAddr | output | 32 | Byte address of the word written |
| memWrData | output | 32 | Word written |
| headPtr | output | 8 | Next slot the producer will fill |
| entryIrq | output | 1 | One-cycle pulse after each completed entry |

## Verification
The bench uses the default widths and switches the run-time ring size between 8, 16 and 256 slots, with a reset before each size. On the 8-slot ring, more than sixteen full passes are short enough to run completely. That lets the bench see the pass count cycle through every value, go from 15 back to 0, and reach 1 again, and it checks every word of every entry against arithmetic expectations. A fixed tail fills the ring to its one-slot-short limit, so the bench can check that a blocked descriptor is ignored. The 256-slot ring exercises the full-width head wrap.

// File: rtl/lap_ring_pkg.sv
package lap_ring_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_WRITE = 1'b1
  } prodStateT;

  // strobes from control into datapath
  typedef struct packed {
    logic loadDesc;   // capture offered descriptor, start new entry
    logic writeWord;  // present current word on the memory port
    logic commit;     // last word written: advance head
  } ringStrobeT;

endpackage

// File: rtl/lap_ring_ctrl.sv
module lap_ring_ctrl
  import lap_ring_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       descValid,
  input  logic       ringFull,
  input  logic       lastWord,
  output logic       descReady,
  output ringStrobeT strobe,
  output logic       entryIrq
);

  prodStateT state, stateNext;

  always_comb begin
    strobe    = '0;
    descReady = 1'b0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        descReady = !ringFull;
        if (descValid && !ringFull) begin
          strobe.loadDesc = 1'b1;
          stateNext       = ST_WRITE;
        end
      end
      ST_WRITE: begin
        strobe.writeWord = 1'b1;
        if (lastWord) begin
          strobe.commit = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      entryIrq <= 1'b0;
    end else begin
      state    <= stateNext;
      entryIrq <= strobe.commit;
    end
  end

endmodule

// File: rtl/lap_ring_datapath.sv
module lap_ring_datapath
  import lap_ring_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int DESC_WORDS = 8,
  parameter int ADDR_W     = 32,
  parameter int PTR_W      = 8,
  parameter int MIN_LOG2   = 3,
  parameter int LAP_W      = 4,
  parameter int ID_W       = 8,
  parameter int SZ_W       = $clog2(PTR_W + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ringStrobeT                   strobe,
  input  logic [DESC_WORDS*WORD_W-1:0] descData,
  input  logic [ID_W-1:0]              ringId,
  input  logic [ADDR_W-1:0]            ringBase,
  input  logic [SZ_W-1:0]              ringSizeLog2,
  input  logic [PTR_W-1:0]             tailPtr,
  output logic                         ringFull,
  output logic                         lastWord,
  output logic                         memWrEn,
  output logic [ADDR_W-1:0]            memWrAddr,
  output logic [WORD_W-1:0]            memWrData,
  output logic [PTR_W-1:0]             headPtr
);

  localparam int WIDX_W      = $clog2(DESC_WORDS);
  localparam int BYTE_SHIFT  = $clog2(WORD_W / 8);
  localparam int ENTRY_SHIFT = WIDX_W + BYTE_SHIFT;
  localparam int LAP_HI      = WORD_W - 1;
  localparam int ID_HI       = WORD_W - 1 - LAP_W;

  logic [WORD_W-1:0] descReg [DESC_WORDS];
  logic [WIDX_W-1:0] wordIdx;
  logic [PTR_W-1:0]  head;
  logic [LAP_W-1:0]  lapCnt;
  logic [SZ_W-1:0]   effLog2;
  logic [PTR_W-1:0]  sizeMask;
  logic [PTR_W-1:0]  headNext;
  logic [WORD_W-1:0] curWord;

  // descriptor hold register, one lane per word
  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (strobe.loadDesc) descReg[g] <= descData[g*WORD_W +: WORD_W];
    end
  end

  // ring geometry
  always_comb begin
    if (ringSizeLog2 < SZ_W'(MIN_LOG2))   effLog2 = SZ_W'(MIN_LOG2);
    else if (ringSizeLog2 > SZ_W'(PTR_W)) effLog2 = SZ_W'(PTR_W);
    else                                  effLog2 = ringSizeLog2;
    sizeMask = ~({PTR_W{1'b1}} << effLog2);
    headNext = (head + PTR_W'(1)) & sizeMask;
    ringFull = (headNext == (tailPtr & sizeMask));
  end

  assign lastWord = (wordIdx == WIDX_W'(DESC_WORDS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordIdx <= '0;
      head    <= '0;
      lapCnt  <= '0;
    end else begin
      if (strobe.loadDesc) begin
        wordIdx <= '0;
        if (head == '0) lapCnt <= lapCnt + LAP_W'(1);
      end else if (strobe.writeWord && !lastWord) begin
        wordIdx <= wordIdx + WIDX_W'(1);
      end
      if (strobe.commit) head <= headNext;
    end
  end

  // stamping of the final word
  always_comb begin
    curWord = descReg[wordIdx];
    if (lastWord) begin
      curWord[LAP_HI -: LAP_W] = lapCnt;
      curWord[ID_HI -: ID_W]   = ringId;
    end
  end

  assign memWrEn   = strobe.writeWord;
  assign memWrData = curWord;
  assign memWrAddr = ringBase
                   + ADDR_W'({head, {ENTRY_SHIFT{1'b0}}})
                   + ADDR_W'({wordIdx, {BYTE_SHIFT{1'b0}}});
  assign headPtr   = head;

endmodule

// File: rtl/lap_ring_producer.sv
module lap_ring_producer
  import lap_ring_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int DESC_WORDS = 8,
  parameter int ADDR_W     = 32,
  parameter int PTR_W      = 8,
  parameter int MIN_LOG2   = 3,
  parameter int LAP_W      = 4,
  parameter int ID_W       = 8,
  parameter int SZ_W       = $clog2(PTR_W + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         descValid,
  input  logic [DESC_WORDS*WORD_W-1:0] descData,
  output logic                         descReady,
  input  logic [ID_W-1:0]              ringId,
  input  logic [ADDR_W-1:0]            ringBase,
  input  logic [SZ_W-1:0]              ringSizeLog2,
  input  logic [PTR_W-1:0]             tailPtr,
  output logic                         memWrEn,
  output logic [ADDR_W-1:0]            memWrAddr,
  output logic [WORD_W-1:0]            memWrData,
  output logic [PTR_W-1:0]             headPtr,
  output logic                         entryIrq
);

  ringStrobeT strobe;
  logic       ringFull;
  logic       lastWord;

  lap_ring_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .descValid(descValid),
    .ringFull (ringFull),
    .lastWord (lastWord),
    .descReady(descReady),
    .strobe   (strobe),
    .entryIrq (entryIrq)
  );

  lap_ring_datapath #(
    .WORD_W    (WORD_W),
    .DESC_WORDS(DESC_WORDS),
    .ADDR_W    (ADDR_W),
    .PTR_W     (PTR_W),
    .MIN_LOG2  (MIN_LOG2),
    .LAP_W     (LAP_W),
    .ID_W      (ID_W),
    .SZ_W      (SZ_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .descData    (descData),
    .ringId      (ringId),
    .ringBase    (ringBase),
    .ringSizeLog2(ringSizeLog2),
    .tailPtr     (tailPtr),
    .ringFull    (ringFull),
    .lastWord    (lastWord),
    .memWrEn     (memWrEn),
    .memWrAddr   (memWrAddr),
    .memWrData   (memWrData),
    .headPtr     (headPtr)
  );

endmodule

// File: rtl/lap_ring_checker.sv
module lap_ring_checker #(
  parameter int WORD_W     = 32,
  parameter int DESC_WORDS = 8,
  parameter int ADDR_W     = 32,
  parameter int PTR_W      = 8,
  parameter int MIN_LOG2   = 3,
  parameter int ID_W       = 8,
  parameter int SZ_W       = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              descReady,
  input logic [ID_W-1:0]   ringId,
  input logic [SZ_W-1:0]   ringSizeLog2,
  input logic [PTR_W-1:0]  tailPtr,
  input logic              memWrEn,
  input logic [ADDR_W-1:0] memWrAddr,
  input logic [ID_W-1:0]   stampedId,
  input logic [PTR_W-1:0]  headPtr,
  input logic              entryIrq
);

  localparam int WIDX_W     = $clog2(DESC_WORDS);
  localparam int BYTE_SHIFT = $clog2(WORD_W / 8);
  localparam int STEP       = WORD_W / 8;

  logic [SZ_W-1:0]   chkLog2;
  logic [PTR_W-1:0]  chkMask;
  logic [WIDX_W-1:0] addrWord;

  always_comb begin
    if (ringSizeLog2 < SZ_W'(MIN_LOG2))   chkLog2 = SZ_W'(MIN_LOG2);
    else if (ringSizeLog2 > SZ_W'(PTR_W)) chkLog2 = SZ_W'(PTR_W);
    else                                  chkLog2 = ringSizeLog2;
    chkMask = ~({PTR_W{1'b1}} << chkLog2);
  end

  assign addrWord = memWrAddr[BYTE_SHIFT +: WIDX_W];

  p_ready_not_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    descReady |-> (((headPtr + PTR_W'(1)) & chkMask) != (tailPtr & chkMask)));

  p_head_in_ring_r6: assert property (@(posedge clk) disable iff (!rstN)
    (headPtr & ~chkMask) == '0);

  p_head_moves_with_irq_r6: assert property (@(posedge clk) disable iff (!rstN)
    (headPtr != $past(headPtr)) |-> entryIrq);

  p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> !descReady);

  p_word_stride_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && $past(memWrEn)) |-> (memWrAddr == $past(memWrAddr) + ADDR_W'(STEP)));

  p_first_word_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWrEn) |-> (addrWord == '0));

  p_id_stamp_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && addrWord == WIDX_W'(DESC_WORDS - 1)) |-> (stampedId == ringId));

  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    entryIrq |=> !entryIrq);

  p_irq_after_last_r9: assert property (@(posedge clk) disable iff (!rstN)
    entryIrq |-> ($past(memWrEn) && $past(addrWord) == WIDX_W'(DESC_WORDS - 1)));

endmodule

bind lap_ring_producer lap_ring_checker #(
  .WORD_W    (WORD_W),
  .DESC_WORDS(DESC_WORDS),
  .ADDR_W    (ADDR_W),
  .PTR_W     (PTR_W),
  .MIN_LOG2  (MIN_LOG2),
  .ID_W      (ID_W),
  .SZ_W      (SZ_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .descReady   (descReady),
  .ringId      (ringId),
  .ringSizeLog2(ringSizeLog2),
  .tailPtr     (tailPtr),
  .memWrEn     (memWrEn),
  .memWrAddr   (memWrAddr),
  .stampedId   (memWrData[WORD_W-1-LAP_W -: ID_W]),
  .headPtr     (headPtr),
  .entryIrq    (entryIrq)
);

// File: tb/lap_ring_producer_bench.sv
module lap_ring_producer_bench;

  logic         clk = 1'b0;
  logic         rstN;
  logic         descValid;
  logic [255:0] descData;
  logic         descReady;
  logic [7:0]   ringId;
  logic [31:0]  ringBase;
  logic [3:0]   ringSizeLog2;
  logic [7:0]   tailPtr;
  logic         memWrEn;
  logic [31:0]  memWrAddr;
  logic [31:0]  memWrData;
  logic [7:0]   headPtr;
  logic         entryIrq;

  always #5 clk = ~clk;

  lap_ring_producer u_lap_ring_producer (
    .clk(clk), .rstN(rstN), .descValid(descValid), .descData(descData),
    .descReady(descReady), .ringId(ringId), .ringBase(ringBase),
    .ringSizeLog2(ringSizeLog2), .tailPtr(tailPtr), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .headPtr(headPtr),
    .entryIrq(entryIrq)
  );

  int vecCount = 0;
  int missCount = 0;
  int seqNum = 0;
  int headExp = 0;
  int lapExp = 0;
  int passNum = 0;
  int sizeExp = 8;

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    vecCount++;
    if (act != exp) begin
      missCount++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] patWord(input int s, input int w);
    logic [31:0] a, b;
    a = 32'(s) * 32'h9E37_79B1;
    b = 32'(w + 1) * 32'h85EB_CA6B;
    return a ^ b ^ 32'hF5A0_0000;
  endfunction

  task automatic doReset(input int log2v, input logic [7:0] idv,
                         input logic [31:0] basev);
    rstN = 1'b0;
    descValid = 1'b0;
    descData = '0;
    tailPtr = '0;
    ringSizeLog2 = 4'(log2v);
    ringId = idv;
    ringBase = basev;
    sizeExp = 1 << log2v;
    headExp = 0;
    lapExp = 0;
    passNum = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // offers one descriptor at a negedge, checks its eight writes and the pulse
  task automatic sendEntry(input bit moveTail);
    logic [31:0] expW;
    for (int w = 0; w < 8; w++) descData[w*32 +: 32] = patWord(seqNum, w);
    descValid = 1'b1;
    chk("R7", "descReady before offer", longint'(descReady), 1);
    if (headExp == 0) begin
      lapExp = (lapExp + 1) % 16;
      passNum++;
    end
    @(negedge clk);
    for (int w = 0; w < 8; w++) begin
      descData = ~descData;  // must not be captured (R8)
      chk("R2", "memWrEn", longint'(memWrEn), 1);
      chk("R2", "address", longint'(memWrAddr),
          longint'(ringBase + 32'(headExp * 32 + w * 4)));
      chk("R8", "descReady while writing", longint'(descReady), 0);
      expW = patWord(seqNum, w);
      if (w < 7) begin
        chk("R2", "word data", longint'(memWrData), longint'(expW));
      end else begin
        chk("R3", "stamped id and low bits", longint'(memWrData[27:0]),
            longint'({ringId, expW[19:0]}));
        if (passNum == 1)
          chk("R4", "first pass lap", longint'(memWrData[31:28]), longint'(lapExp));
        else
          chk("R5", "lap count", longint'(memWrData[31:28]), longint'(lapExp));
      end
      @(negedge clk);
    end
    descValid = 1'b0;
    headExp = (headExp + 1) % sizeExp;
    chk("R9", "irq after last word", longint'(entryIrq), 1);
    chk("R9", "no write in irq cycle", longint'(memWrEn), 0);
    chk("R6", "head advanced", longint'(headPtr), longint'(headExp));
    if (moveTail) tailPtr = 8'(headExp);
    @(negedge clk);
    chk("R9", "irq single cycle", longint'(entryIrq), 0);
    seqNum++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    missCount++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    // R1: reset state
    doReset(3, 8'h5C, 32'h1000_0000);
    chk("R1", "headPtr", longint'(headPtr), 0);
    chk("R1", "memWrEn", longint'(memWrEn), 0);
    chk("R1", "entryIrq", longint'(entryIrq), 0);
    chk("R1", "descReady", longint'(descReady), 1);

    // 8-slot ring, consumer keeps up: 17 passes plus 3 covers lap 15 -> 0 -> 1
    for (int i = 0; i < 139; i++) sendEntry(1'b1);

    // R7: fill against a fixed tail
    doReset(3, 8'h3E, 32'h0004_0100);
    for (int i = 0; i < 7; i++) sendEntry(1'b0);
    chk("R7", "full: descReady low", longint'(descReady), 0);
    descValid = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R7", "full: no write", longint'(memWrEn), 0);
      chk("R7", "full: head held", longint'(headPtr), 7);
      chk("R7", "full: no irq", longint'(entryIrq), 0);
    end
    descValid = 1'b0;
    tailPtr = 8'd3;
    @(negedge clk);
    chk("R7", "space freed: ready", longint'(descReady), 1);
    for (int i = 0; i < 3; i++) sendEntry(1'b0);
    chk("R7", "full again at head 2", longint'(descReady), 0);
    tailPtr = 8'(headExp);
    @(negedge clk);
    for (int i = 0; i < 6; i++) sendEntry(1'b1);

    // 16-slot ring
    doReset(4, 8'hC7, 32'h2000_0000);
    for (int i = 0; i < 40; i++) sendEntry(1'b1);

    // 256-slot ring, full-width head wrap
    doReset(8, 8'hA3, 32'h8001_0000);
    for (int i = 0; i < 260; i++) sendEntry(1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

endmodule